// File: doc/BRIEF.md
# OSD Character Raster Sequencer

This block turns a small character screen held in on-chip storage into a stream of character cells for an on-screen-display overlay. A processor fills a 64-word character store through a write port. The port has an address pointer that moves forward by itself after every write. On the display side, a position generator tells the block when a frame starts, when a scan line is active and which cycles carry a pixel. The block then walks the store and presents, for every pixel of a character cell, the store address, the character code and its attributes, and the glyph column and glyph row that a font lookup further downstream needs.

Text rows have a variable length. A row ends at a carriage-return code stored among the characters. Each row has its own magnification of 1 to 4, which applies to both pixel width and scan-line height. Between rows there is a programmable blank band of 0, 4, 8 or 12 scan lines. Font contents and colour mixing belong to other blocks.

Top module: `osd_raster_seq`

## Requirements
- R1: The store holds 64 words of 10 bits. For the word at `rd_addr`, `char_code` presents bits [5:0], `char_color` presents bits [8:6] and `char_blink` presents bit 9.
- R2: `cpu_ptr_load` sets the write pointer to `cpu_ptr_value`. Each `cpu_wr_en` stores `cpu_wr_data` at the pointer and then advances the pointer by one, so that address 63 is followed by address 0.
- R3: A glyph cell is 12 columns by 18 rows. `glyph_col` stays within 0..11 and `glyph_row` within 0..17. After the last pixel of column 11, the next cell pixel is column 0 of the next address, with no gap between characters.
- R4: The magnification s is the 2-bit field of `row_scale_tbl` plus one; field i sits at bits [2i+1:2i]. Each glyph column lasts s pixel cycles.
- R5: Each glyph row lasts s scan lines. Text row i uses field i, and every text row from MAX_ROWS-1 onward uses the last field. A scan line ends on the falling edge of `line_active`.
- R6: Code 63 (carriage return) is never shown. It ends output for the rest of the scan line. Each further scan line of the same text row starts again at the row's first address.
- R7: After the last of its 18·s scan lines, a text row is followed by 4·`gap_sel` scan lines with no output. The next text row then begins at the word after its carriage return.
- R8: Code 62 is a blank cell: `cell_valid` is high and `fg_on` is low. For every other shown code, `fg_on` equals `cell_valid`.
- R9: Once address 63 has been consumed, either as a carriage return or as the final character of a row, no cell is output until the next `frame_start`.
- R10: After reset the block is idle: no output, with `rd_addr`, `glyph_col` and `glyph_row` at 0. `frame_start` restarts at address 0, text row 0, column 0, glyph row 0.
- R11: A cell is output only in cycles where both `line_active` and `pix_active` are high. A cycle with `pix_active` low holds the position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_ptr_load | input | 1 | Load the write pointer |
| cpu_ptr_value | input | 6 | New write pointer value |
| cpu_wr_en | input | 1 | Store a word at the pointer |
| cpu_wr_data | input | 10 | Word to store |
| frame_start | input | 1 | Start of the overlay frame |
| line_active | input | 1 | Scan line inside the overlay |
| pix_active | input | 1 | This cycle carries a pixel |
| row_scale_tbl | input | 2·MAX_ROWS | Magnification field per text row |
| gap_sel | input | 2 | Blank band between rows, in units of 4 lines |
| rd_addr | output | 6 | Store address being shown |
| char_code | output | 6 | Character code of that word |
| char_color | output | 3 | Foreground colour of that word |
| char_blink | output | 1 | Blink flag of that word |
| glyph_col | output | 4 | Font column 0..11 |
| glyph_row | output | 5 | Font row 0..17 |
| cell_valid | output | 1 | A character cell pixel is presented |
| fg_on | output | 1 | The presented cell may draw foreground |

## Verification
The assertions assume that `frame_start` arrives while `line_active` is low, and that the scale table and gap setting stay fixed during a frame. They also assume that a scan line offers enough pixel cycles to reach the row's carriage return. The stimulus respects all three. It pulses `frame_start` only between lines and changes configuration only before a new frame. It sizes each line longer than the widest row at that row's magnification, and inserts pixel-less cycles inside lines so that the hold behaviour is covered as well.

// File: rtl/osd_seq_pkg.sv
package osd_seq_pkg;
  localparam int CODE_W    = 6;
  localparam int COLOR_W   = 3;
  localparam int WORD_W    = 1 + COLOR_W + CODE_W;
  localparam int GLYPH_COLS = 12;
  localparam int GLYPH_ROWS = 18;
  localparam logic [CODE_W-1:0] CODE_CR    = 6'd63;
  localparam logic [CODE_W-1:0] CODE_BLANK = 6'd62;

  typedef struct packed {
    logic               blink;
    logic [COLOR_W-1:0] color;
    logic [CODE_W-1:0]  code;
  } osd_word_t;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_ROW, SEQ_GAP, SEQ_DONE} seq_state_t;

  // magnification from a 2-bit field: 1..4
  function automatic logic [2:0] scale_of(input logic [1:0] sel);
    return {1'b0, sel} + 3'd1;
  endfunction

  // blank scan lines between text rows: 0, 4, 8, 12
  function automatic logic [3:0] gap_lines_of(input logic [1:0] sel);
    return {sel, 2'b00};
  endfunction
endpackage

// File: rtl/osd_char_ram.sv
module osd_char_ram #(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ptr_load,
  input  logic [ADDR_W-1:0] ptr_value,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] wr_ptr;
  logic [ADDR_W-1:0] eff_ptr;

  assign eff_ptr = ptr_load ? ptr_value : wr_ptr;
  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (wr_en) mem[eff_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     wr_ptr <= '0;
    else if (wr_en) wr_ptr <= eff_ptr + ADDR_W'(1);
    else            wr_ptr <= eff_ptr;
  end

  // R2: a plain write moves the pointer on by one, modulo the depth
  assert_ptr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ptr_load) |=> wr_ptr == ADDR_W'($past(wr_ptr) + ADDR_W'(1)));
endmodule

// File: rtl/osd_glyph_counter.sv
module osd_glyph_counter #(
  parameter int LIMIT = 12,
  parameter int IDX_W = $clog2(LIMIT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic [2:0]       scale,
  output logic [IDX_W-1:0] idx_o,
  output logic             wrap_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LIMIT - 1);

  logic [1:0] sub;
  logic       last_sub;

  assign last_sub = ({1'b0, sub} == scale - 3'd1);
  assign wrap_o   = step && last_sub && (idx_o == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub   <= '0;
      idx_o <= '0;
    end else if (clear) begin
      sub   <= '0;
      idx_o <= '0;
    end else if (step) begin
      if (last_sub) begin
        sub   <= '0;
        idx_o <= (idx_o == LAST_IDX) ? '0 : idx_o + IDX_W'(1);
      end else begin
        sub <= sub + 2'd1;
      end
    end
  end

  // R3: index stays inside the glyph
  assert_idx_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    idx_o <= LAST_IDX);
  // R4 (horizontal instance) / R5 (vertical instance): replication holds the index
  assert_sub_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !last_sub && !clear) |=> $stable(idx_o));
endmodule

// File: rtl/osd_raster_seq.sv
module osd_raster_seq
  import osd_seq_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int MAX_ROWS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cpu_ptr_load,
  input  logic [ADDR_W-1:0]     cpu_ptr_value,
  input  logic                  cpu_wr_en,
  input  logic [WORD_W-1:0]     cpu_wr_data,
  input  logic                  frame_start,
  input  logic                  line_active,
  input  logic                  pix_active,
  input  logic [2*MAX_ROWS-1:0] row_scale_tbl,
  input  logic [1:0]            gap_sel,
  output logic [ADDR_W-1:0]     rd_addr,
  output logic [CODE_W-1:0]     char_code,
  output logic [COLOR_W-1:0]    char_color,
  output logic                  char_blink,
  output logic [3:0]            glyph_col,
  output logic [4:0]            glyph_row,
  output logic                  cell_valid,
  output logic                  fg_on
);
  localparam int ROW_W = (MAX_ROWS > 1) ? $clog2(MAX_ROWS) : 1;
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'((1 << ADDR_W) - 1);
  localparam logic [ROW_W-1:0]  LAST_ROW  = ROW_W'(MAX_ROWS - 1);

  seq_state_t        state;
  logic              line_q;
  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] rd_ptr;
  logic              halt;
  logic [ROW_W-1:0]  row_idx;
  logic [3:0]        gap_cnt;
  logic [WORD_W-1:0] rd_data;
  osd_word_t         word;

  // named internal events
  logic       line_end, in_row, pix_slot, hit_cr, emit, char_done, row_done;
  logic [2:0] scale;

  assign word      = osd_word_t'(rd_data);
  assign line_end  = line_q && !line_active;
  assign in_row    = (state == SEQ_ROW);
  assign pix_slot  = in_row && line_active && pix_active && !halt;
  assign hit_cr    = pix_slot && (word.code == CODE_CR);
  assign emit      = pix_slot && (word.code != CODE_CR);
  assign scale     = scale_of(row_scale_tbl[int'(row_idx)*2 +: 2]);

  osd_char_ram #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .ptr_load  (cpu_ptr_load),
    .ptr_value (cpu_ptr_value),
    .wr_en     (cpu_wr_en),
    .wr_data   (cpu_wr_data),
    .rd_addr   (rd_ptr),
    .rd_data   (rd_data)
  );

  osd_glyph_counter #(.LIMIT(GLYPH_COLS), .IDX_W(4)) u_hcount (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (frame_start || line_end),
    .step   (emit),
    .scale  (scale),
    .idx_o  (glyph_col),
    .wrap_o (char_done)
  );

  osd_glyph_counter #(.LIMIT(GLYPH_ROWS), .IDX_W(5)) u_vcount (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (frame_start),
    .step   (in_row && line_end),
    .scale  (scale),
    .idx_o  (glyph_row),
    .wrap_o (row_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= 1'b0;
    else        line_q <= line_active;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SEQ_IDLE;
      base    <= '0;
      rd_ptr  <= '0;
      halt    <= 1'b0;
      row_idx <= '0;
      gap_cnt <= '0;
    end else if (frame_start) begin
      state   <= SEQ_ROW;
      base    <= '0;
      rd_ptr  <= '0;
      halt    <= 1'b0;
      row_idx <= '0;
      gap_cnt <= '0;
    end else begin
      case (state)
        SEQ_ROW: begin
          if (line_end) begin
            halt <= 1'b0;
            if (row_done) begin
              if (rd_ptr == LAST_ADDR) begin
                state <= SEQ_DONE;
              end else begin
                base    <= rd_ptr + ADDR_W'(1);
                rd_ptr  <= rd_ptr + ADDR_W'(1);
                gap_cnt <= '0;
                if (row_idx != LAST_ROW) row_idx <= row_idx + ROW_W'(1);
                if (gap_lines_of(gap_sel) != 4'd0) state <= SEQ_GAP;
              end
            end else begin
              rd_ptr <= base;
            end
          end else if (hit_cr) begin
            halt <= 1'b1;
          end else if (char_done) begin
            if (rd_ptr == LAST_ADDR) halt <= 1'b1;
            else                     rd_ptr <= rd_ptr + ADDR_W'(1);
          end
        end
        SEQ_GAP: begin
          if (line_end) begin
            if (gap_cnt == gap_lines_of(gap_sel) - 4'd1) state <= SEQ_ROW;
            else                                        gap_cnt <= gap_cnt + 4'd1;
          end
        end
        default: ;
      endcase
    end
  end

  assign rd_addr    = rd_ptr;
  assign char_code  = word.code;
  assign char_color = word.color;
  assign char_blink = word.blink;
  assign cell_valid = emit;
  assign fg_on      = emit && (word.code != CODE_BLANK);

  assert_cr_hidden_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cell_valid |-> char_code != CODE_CR);
  assert_line_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_row && line_end && !row_done && !frame_start) |=> rd_addr == $past(base));
  assert_gap_dark_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SEQ_GAP) |-> !cell_valid);
  assert_blank_no_fg_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_valid && char_code == CODE_BLANK) |-> !fg_on);
  assert_done_dark_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SEQ_DONE) |-> !cell_valid);
  assert_frame_home_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (rd_addr == '0 && glyph_col == '0 && glyph_row == '0));
  assert_pix_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cell_valid |-> (line_active && pix_active));
endmodule

// File: tb/test_osd_raster_seq.sv
module test_osd_raster_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_ptr_load = 1'b0;
  logic [5:0] cpu_ptr_value = '0;
  logic       cpu_wr_en = 1'b0;
  logic [9:0] cpu_wr_data = '0;
  logic       frame_start = 1'b0;
  logic       line_active = 1'b0;
  logic       pix_active = 1'b0;
  logic [7:0] row_scale_tbl = '0;
  logic [1:0] gap_sel = '0;
  logic [5:0] rd_addr;
  logic [5:0] char_code;
  logic [2:0] char_color;
  logic       char_blink;
  logic [3:0] glyph_col;
  logic [4:0] glyph_row;
  logic       cell_valid;
  logic       fg_on;

  always #4 clk = ~clk;

  osd_raster_seq #(.ADDR_W(6), .MAX_ROWS(4)) i_osd_raster_seq (
    .clk(clk), .rst_n(rst_n),
    .cpu_ptr_load(cpu_ptr_load), .cpu_ptr_value(cpu_ptr_value),
    .cpu_wr_en(cpu_wr_en), .cpu_wr_data(cpu_wr_data),
    .frame_start(frame_start), .line_active(line_active), .pix_active(pix_active),
    .row_scale_tbl(row_scale_tbl), .gap_sel(gap_sel),
    .rd_addr(rd_addr), .char_code(char_code), .char_color(char_color),
    .char_blink(char_blink), .glyph_col(glyph_col), .glyph_row(glyph_row),
    .cell_valid(cell_valid), .fg_on(fg_on)
  );

  typedef struct {
    bit         valid;
    logic [5:0] addr;
    logic [9:0] word;
    logic [3:0] col;
    logic [4:0] row;
    string      tag;
  } exp_t;

  exp_t       sb_q[$];
  int         n_checks = 0;
  int         n_fails = 0;
  logic [9:0] bmem [64];
  logic [5:0] bptr = '0;
  int         tbl [4];
  localparam int IDLE_CYC = 6;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic exp_t none_item(input string tag);
    exp_t e;
    e.valid = 0; e.addr = '0; e.word = '0; e.col = '0; e.row = '0; e.tag = tag;
    return e;
  endfunction

  function automatic logic [9:0] mk_word(input int code);
    logic [5:0] c;
    c = 6'(code);
    return {c[0], c[2:0], c};
  endfunction

  // monitor: pop one expectation per driven display cycle
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        if (!e.valid) begin
          check(cell_valid == 1'b0 && fg_on == 1'b0, e.tag, "idle cell",
                {cell_valid, fg_on}, 0);
        end else begin
          check(cell_valid == 1'b1, e.tag, "cell_valid", cell_valid, 1);
          check(rd_addr == e.addr, "R7", "rd_addr", rd_addr, e.addr);
          check({char_blink, char_color, char_code} == e.word,
                (e.addr == 0) ? "R2" : "R1", "word", {char_blink, char_color, char_code}, e.word);
          check(glyph_col == e.col, "R3 R4", "glyph_col", glyph_col, e.col);
          check(glyph_row == e.row, "R3 R5", "glyph_row", glyph_row, e.row);
          check(fg_on == (e.word[5:0] != 6'd62), "R8", "fg_on", fg_on, e.word[5:0] != 6'd62);
        end
      end
    end
  end

  task automatic drive(input bit fs, input bit la, input bit pa, input exp_t e);
    @(negedge clk);
    frame_start = fs; line_active = la; pix_active = pa;
    cpu_wr_en = 1'b0; cpu_ptr_load = 1'b0;
    sb_q.push_back(e);
  endtask

  task automatic cpu_set(input int p);
    @(negedge clk);
    cpu_ptr_load = 1'b1; cpu_ptr_value = 6'(p); cpu_wr_en = 1'b0;
    bptr = 6'(p);
  endtask

  task automatic cpu_write(input logic [9:0] d);
    @(negedge clk);
    cpu_ptr_load = 1'b0; cpu_wr_en = 1'b1; cpu_wr_data = d;
    bmem[bptr] = d;
    bptr = bptr + 6'd1;
  endtask

  task automatic cpu_idle();
    @(negedge clk);
    cpu_ptr_load = 1'b0; cpu_wr_en = 1'b0;
  endtask

  // one scan line; list holds the row's displayable addresses
  task automatic run_line(input int list[$], input int s, input int v, input int cyc,
                          input int pmod, input string empty_tag);
    int k = 0;
    for (int c = 0; c < cyc; c++) begin
      bit pa;
      pa = (pmod == 0) ? 1'b1 : ((c % pmod) != (pmod - 1));
      if (!pa) begin
        drive(0, 1, 0, none_item("R11"));
      end else begin
        int ci;
        exp_t e;
        ci = k / (12 * s);
        if (ci < list.size()) begin
          e.valid = 1;
          e.addr = 6'(list[ci]);
          e.word = bmem[list[ci]];
          e.col  = 4'((k % (12 * s)) / s);
          e.row  = 5'(v / s);
          e.tag  = "R4";
        end else begin
          e = none_item(empty_tag);
        end
        k++;
        drive(0, 1, 1, e);
      end
    end
    for (int i = 0; i < IDLE_CYC; i++) drive(0, 0, 0, none_item("R11"));
  endtask

  task automatic run_frame(input int rows_lim, input int cyc, input int pmod,
                           input int extra_lines);
    int  base = 0;
    bit  done = 0;
    int  empty[$];
    drive(1, 0, 0, none_item("R10"));
    for (int ri = 0; ri < rows_lim && !done; ri++) begin
      int list[$];
      int a;
      int last;
      int s;
      s = tbl[(ri > 3) ? 3 : ri] + 1;
      a = base;
      while (1) begin
        if (bmem[a][5:0] == 6'd63) begin last = a; break; end
        list.push_back(a);
        if (a == 63) begin last = a; break; end
        a++;
      end
      for (int v = 0; v < 18 * s; v++) run_line(list, s, v, cyc, pmod, "R6");
      if (last == 63) done = 1;
      else base = last + 1;
      if (!done)
        for (int g = 0; g < 4 * int'(gap_sel); g++) run_line(empty, 1, 0, cyc, pmod, "R7");
    end
    for (int x = 0; x < extra_lines; x++)
      run_line(empty, 1, 0, cyc, pmod, done ? "R9" : "R7");
  endtask

  function automatic int layout1(input int a);
    case (a)
      0: return 1;   1: return 2;   2: return 62;  3: return 63;
      4: return 5;   5: return 63;
      6: return 7;   7: return 63;
      8: return 63;
      9: return 10;  10: return 63;
      default: return 63;
    endcase
  endfunction

  function automatic int layout2(input int a);
    if (a == 0)  return 3;
    if (a == 1)  return 63;
    if (a == 62) return 63;
    if (a == 63) return 20;
    return a;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    // R10: reset state
    check(cell_valid == 1'b0, "R10", "reset cell_valid", cell_valid, 0);
    check(rd_addr == 6'd0,    "R10", "reset rd_addr", rd_addr, 0);
    check(glyph_col == 4'd0,  "R10", "reset glyph_col", glyph_col, 0);
    check(glyph_row == 5'd0,  "R10", "reset glyph_row", glyph_row, 0);
    check(fg_on == 1'b0,      "R10", "reset fg_on", fg_on, 0);

    // layout 1: word 0 first written as junk, fixed by the wrapped 65th write (R2)
    cpu_set(0);
    for (int a = 0; a < 64; a++) cpu_write((a == 0) ? 10'h155 : mk_word(layout1(a)));
    cpu_write(mk_word(layout1(0)));
    cpu_idle();

    // R10: lines before any frame_start show nothing
    begin
      int empty[$];
      for (int i = 0; i < 2; i++) run_line(empty, 1, 0, 20, 0, "R10");
    end

    // frame 1: scales 1,2,4,3 then saturated (R5), gap 4 lines, pixel holes (R11)
    tbl[0] = 0; tbl[1] = 1; tbl[2] = 3; tbl[3] = 2;
    row_scale_tbl = {2'd2, 2'd3, 2'd1, 2'd0};
    gap_sel = 2'd1;
    run_frame(5, 64, 5, 0);

    // layout 2 loaded from pointer 40 with wrap (R2); row reaching address 63 (R9)
    cpu_set(40);
    for (int i = 0; i < 64; i++) cpu_write(mk_word(layout2((40 + i) % 64)));
    cpu_idle();
    tbl[0] = 0; tbl[1] = 0; tbl[2] = 0; tbl[3] = 0;
    row_scale_tbl = '0;
    gap_sel = 2'd3;
    run_frame(10, 740, 0, 4);

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule